// File: doc/BRIEF.md
# Sample-Queued Pulse-Width Modulator

This block drives one pulse-width modulated output. Software reaches it through four 32-bit registers on a simple synchronous write bus with a combinational read port. Duty values are not written straight to the compare logic. Each one is pushed into a small queue of samples. The period counter takes exactly one sample from that queue at the start of every period. A driver can therefore stage up to four duty values ahead, and every change takes effect on a period boundary without a glitch.

The counter steps on a selectable source: every bus clock cycle, or a strobe `hf_tick` from a faster clock that is already synchronised to `clk`. A programmable divider sits between the source and the counter. One period lasts the period register value plus two divided steps. The output is active from the start of a period for as many steps as the current sample value, then inactive until the period ends. An inversion bit flips the output level. A self-clearing soft reset empties the queue and returns every register to zero. Three low-power run flags are held and read back only.

The control path is a three-state machine. IDLE means the output is stopped. RUN means the counter is running. SWRST is a fixed-length soft reset. The transitions are:
- *enable* (IDLE to RUN): a control write with bit 0 set and bit 3 clear. The first sample is loaded on this edge.
- *stop* (RUN to IDLE): a control write with bit 0 clear and bit 3 clear.
- *soft_reset* (IDLE or RUN to SWRST): a control write with bit 3 set.
- *reset_done* (SWRST to IDLE): the reset countdown reaches zero.

All other writes leave the state unchanged.

Top module: `pwm_fifo_ctrl`

## Requirements
- R1: After a hardware reset, the control, status and period registers read 0 and `pwm_out` is 0.
- R2: Register addresses are 0 = control, 1 = status, 2 = sample (write only, reads 0) and 3 = period (low 16 bits). Control bits read back as written: bit 0 enable, bits 15:4 divider N, bits 17:16 source select, bit 18 inversion, and bits 22, 23 and 24 are storage-only flags.
- R3: A write to address 2 pushes `wdata[15:0]` into a 4-entry queue. Status bits 2:0 give the number of occupied entries, and read 4 when the queue is full.
- R4: A sample write while the queue holds 4 entries is dropped and sets status bit 4. That bit stays set until a status write with bit 4 equal to 1.
- R5: With source select 1, the counter advances once every N+1 clock cycles, and one period lasts (P+2)*(N+1) cycles, where P is the period register value. With P = 0, a period lasts two steps.
- R6: Within a period, `pwm_out` (before inversion) is 1 for the first S steps and 0 for the rest, where S is the current sample. S = 0 gives a period that stays low. S >= P+2 gives a period that stays high.
- R7: The enable edge takes the head sample for the first period. Each later period takes the next sample in write order. When the queue is empty at a boundary, the previous sample is kept.
- R8: With the queue full while running, the count stays 4 until the current period ends. It reads 3 in the cycle after the period's last step.
- R9: Control bit 18 inverts `pwm_out` while running.
- R10: Source select 2 advances the counter only in cycles with `hf_tick` high. Select values 0 and 3 stop the counter, so the output holds its level.
- R11: In IDLE, `pwm_out` is 0 whatever the inversion bit. A control write of 0 while running brings `pwm_out` to 0 in the next cycle and keeps the queued samples.
- R12: A control write with bit 3 set clears every register and empties the queue. Control bit 3 then reads 1 for exactly 8 cycles and 0 afterwards. Bus writes during those 8 cycles are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| hf_tick | input | 1 | Alternate counting strobe, synchronous to `clk` |
| pwm_out | output | 1 | Modulated output |

## Verification
Register effects appear on `reg_rdata` one clock edge after the write. The bench therefore reads back at the falling edge that follows the write edge, and for the same reason expects `pwm_out` to fall one cycle after a stop write. The enable edge puts the counter at step 0 in the very next cycle. From that cycle the bench predicts each output bit as (cycle index / (N+1)) mod (P+2) compared against the sample scheduled for that period, and compares one whole period at a time. Queue occupancy changes at the edge that ends a period's last step, so the bench counts cycles from the enable write and samples the status register one cycle before and one cycle after that edge. The soft-reset countdown is checked in its last busy cycle and in the first cycle after it.

// File: rtl/pwm_fifo_pkg.sv
package pwm_fifo_pkg;

    // register word addresses
    localparam logic [1:0] A_CTRL   = 2'd0;
    localparam logic [1:0] A_STAT   = 2'd1;
    localparam logic [1:0] A_SAMPLE = 2'd2;
    localparam logic [1:0] A_PERIOD = 2'd3;

    // control field positions
    localparam int B_EN     = 0;
    localparam int B_SWR    = 3;
    localparam int B_PSC_LO = 4;
    localparam int PSC_W    = 12;
    localparam int B_SEL_LO = 16;
    localparam int B_INV    = 18;
    localparam int B_DBG    = 22;
    localparam int B_WAIT   = 23;
    localparam int B_DOZE   = 24;

    // status field positions
    localparam int B_OVF    = 4;

    // counting source selector
    localparam logic [1:0] SEL_BUS = 2'd1;
    localparam logic [1:0] SEL_HF  = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_SWRST = 2'd2
    } ctl_state_e;

endpackage

// File: rtl/pwm_sample_fifo.sv
module pwm_sample_fifo #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 4,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic [CW-1:0]    count,
    output logic             full,
    output logic             empty
);

    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
    localparam logic [PW-1:0] LAST_P  = PW'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wr_ptr_q, rd_ptr_q;
    logic             push_ok, pop_ok;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == LAST_P) ? '0 : p + 1'b1;
    endfunction

    assign full    = (count == DEPTH_C);
    assign empty   = (count == '0);
    assign push_ok = push & ~full;
    assign pop_ok  = pop & ~empty;
    assign dout    = mem[rd_ptr_q];

    always_ff @(posedge clk) begin
        if (push_ok && !flush) begin
            mem[wr_ptr_q] <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count    <= '0;
        end else if (flush) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count    <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr_q <= step(wr_ptr_q);
            end
            if (pop_ok) begin
                rd_ptr_q <= step(rd_ptr_q);
            end
            unique case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    p_count_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= DEPTH_C);

    p_full_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> (count == DEPTH_C));

    p_flush_empty_r12: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0));

endmodule

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen
    import pwm_fifo_pkg::*;
#(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [1:0]       sel,
    input  logic             hf_tick,
    input  logic [DIV_W-1:0] presc,
    output logic             tick
);

    logic             src;
    logic [DIV_W-1:0] div_q;

    always_comb begin
        unique case (sel)
            SEL_BUS: src = 1'b1;
            SEL_HF:  src = hf_tick;
            default: src = 1'b0;
        endcase
    end

    // >= keeps the divider bounded when the ratio is lowered mid-run
    assign tick = run & src & (div_q >= presc);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (!run) begin
            div_q <= '0;
        end else if (src) begin
            div_q <= (div_q >= presc) ? '0 : div_q + 1'b1;
        end
    end

    p_no_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sel != SEL_BUS && sel != SEL_HF) |-> !tick);

    p_hf_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_HF && !hf_tick) |-> !tick);

    p_div_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (div_q == '0));

endmodule

// File: rtl/pwm_period_core.sv
module pwm_period_core #(
    parameter int SAMPLE_W = 16,
    localparam int CNT_W   = SAMPLE_W + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                start,
    input  logic                run,
    input  logic                tick,
    input  logic [SAMPLE_W-1:0] period,
    input  logic [SAMPLE_W-1:0] head,
    input  logic                head_valid,
    output logic                pop,
    output logic                active
);

    logic [CNT_W-1:0]    cnt_q;
    logic [CNT_W-1:0]    last_c;
    logic [SAMPLE_W-1:0] cmp_q;
    logic                wrap, load;

    // final step of a period is P+1, giving P+2 steps in total
    assign last_c = {1'b0, period} + 1'b1;
    assign wrap   = run & tick & (cnt_q >= last_c);
    assign load   = start | wrap;
    assign pop    = load & head_valid;
    assign active = run & (cnt_q < {1'b0, cmp_q});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            cmp_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
            cmp_q <= '0;
        end else if (start) begin
            cnt_q <= '0;
            if (head_valid) begin
                cmp_q <= head;
            end
        end else if (run && tick) begin
            if (wrap) begin
                cnt_q <= '0;
                if (head_valid) begin
                    cmp_q <= head;
                end
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    p_wrap_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !clear) |=> (cnt_q == '0));

    p_step_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !wrap && !clear && !start) |=> (cnt_q == $past(cnt_q) + 1'b1));

    p_hold_no_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick && !clear && !start) |=> $stable(cnt_q));

    p_empty_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !head_valid && !clear) |=> $stable(cmp_q));

endmodule

// File: rtl/pwm_fifo_ctrl.sv
module pwm_fifo_ctrl
    import pwm_fifo_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int SAMPLE_W   = 16,
    parameter int FIFO_DEPTH = 4,
    parameter int SWR_CYCLES = 8,
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1),
    localparam int SWR_W     = (SWR_CYCLES > 1) ? $clog2(SWR_CYCLES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              hf_tick,
    output logic              pwm_out
);

    ctl_state_e state_q, state_d;

    logic                en_q, inv_q, dbg_q, wait_q, doze_q, ovf_q;
    logic [PSC_W-1:0]    psc_q;
    logic [1:0]          sel_q;
    logic [SAMPLE_W-1:0] period_q;
    logic [SWR_W-1:0]    swr_cnt_q;

    logic                bus_ok, wr_ctrl, wr_stat, wr_sample, wr_period;
    logic                swr_req, start, run, tick;
    logic                fifo_pop, fifo_full, fifo_empty, active;
    logic [SAMPLE_W-1:0] fifo_head;
    logic [CNT_W-1:0]    fifo_count;
    logic                unused_wdata;

    assign unused_wdata = ^reg_wdata;

    // bus decode; nothing is accepted while the soft reset runs
    assign bus_ok    = reg_wr && (state_q != ST_SWRST);
    assign wr_ctrl   = bus_ok && (reg_addr == A_CTRL);
    assign wr_stat   = bus_ok && (reg_addr == A_STAT);
    assign wr_sample = bus_ok && (reg_addr == A_SAMPLE);
    assign wr_period = bus_ok && (reg_addr == A_PERIOD);
    assign swr_req   = wr_ctrl && reg_wdata[B_SWR];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (swr_req) begin
                    state_d = ST_SWRST;
                end else if (wr_ctrl && reg_wdata[B_EN]) begin
                    state_d = ST_RUN;
                end
            end
            ST_RUN: begin
                if (swr_req) begin
                    state_d = ST_SWRST;
                end else if (wr_ctrl && !reg_wdata[B_EN]) begin
                    state_d = ST_IDLE;
                end
            end
            ST_SWRST: begin
                if (swr_cnt_q == '0) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign run   = (state_q == ST_RUN);
    assign start = (state_q == ST_IDLE) && (state_d == ST_RUN);

    // outputs
    always_comb begin
        pwm_out = run ? (active ^ inv_q) : 1'b0;
    end

    // register storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q      <= 1'b0;
            inv_q     <= 1'b0;
            dbg_q     <= 1'b0;
            wait_q    <= 1'b0;
            doze_q    <= 1'b0;
            psc_q     <= '0;
            sel_q     <= '0;
            period_q  <= '0;
            ovf_q     <= 1'b0;
            swr_cnt_q <= '0;
        end else if (swr_req) begin
            en_q      <= 1'b0;
            inv_q     <= 1'b0;
            dbg_q     <= 1'b0;
            wait_q    <= 1'b0;
            doze_q    <= 1'b0;
            psc_q     <= '0;
            sel_q     <= '0;
            period_q  <= '0;
            ovf_q     <= 1'b0;
            swr_cnt_q <= SWR_W'(SWR_CYCLES - 1);
        end else begin
            if (state_q == ST_SWRST && swr_cnt_q != '0) begin
                swr_cnt_q <= swr_cnt_q - 1'b1;
            end
            if (wr_ctrl) begin
                en_q   <= reg_wdata[B_EN];
                inv_q  <= reg_wdata[B_INV];
                dbg_q  <= reg_wdata[B_DBG];
                wait_q <= reg_wdata[B_WAIT];
                doze_q <= reg_wdata[B_DOZE];
                psc_q  <= reg_wdata[B_PSC_LO +: PSC_W];
                sel_q  <= reg_wdata[B_SEL_LO +: 2];
            end
            if (wr_period) begin
                period_q <= reg_wdata[SAMPLE_W-1:0];
            end
            if (wr_sample && fifo_full) begin
                ovf_q <= 1'b1;
            end else if (wr_stat && reg_wdata[B_OVF]) begin
                ovf_q <= 1'b0;
            end
        end
    end

    // read mux
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_CTRL: begin
                reg_rdata[B_EN]                = en_q;
                reg_rdata[B_SWR]               = (state_q == ST_SWRST);
                reg_rdata[B_PSC_LO +: PSC_W]   = psc_q;
                reg_rdata[B_SEL_LO +: 2]       = sel_q;
                reg_rdata[B_INV]               = inv_q;
                reg_rdata[B_DBG]               = dbg_q;
                reg_rdata[B_WAIT]              = wait_q;
                reg_rdata[B_DOZE]              = doze_q;
            end
            A_STAT: begin
                reg_rdata[CNT_W-1:0] = fifo_count;
                reg_rdata[B_OVF]     = ovf_q;
            end
            A_PERIOD: begin
                reg_rdata[SAMPLE_W-1:0] = period_q;
            end
            default: reg_rdata = '0;
        endcase
    end

    pwm_sample_fifo #(
        .WIDTH (SAMPLE_W),
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (swr_req),
        .push  (wr_sample),
        .din   (reg_wdata[SAMPLE_W-1:0]),
        .pop   (fifo_pop),
        .dout  (fifo_head),
        .count (fifo_count),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    pwm_tick_gen #(
        .DIV_W (PSC_W)
    ) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .sel     (sel_q),
        .hf_tick (hf_tick),
        .presc   (psc_q),
        .tick    (tick)
    );

    pwm_period_core #(
        .SAMPLE_W (SAMPLE_W)
    ) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (swr_req),
        .start      (start),
        .run        (run),
        .tick       (tick),
        .period     (period_q),
        .head       (fifo_head),
        .head_valid (!fifo_empty),
        .pop        (fifo_pop),
        .active     (active)
    );

    p_run_has_en_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> en_q);

    p_idle_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_RUN) |-> !pwm_out);

    p_ovf_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sample && fifo_full) |=> ovf_q);

    p_swr_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SWRST && $past(state_q == ST_SWRST)) |-> ($stable(period_q) && fifo_empty));

    p_swr_exit_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SWRST && swr_cnt_q == '0) |=> (state_q == ST_IDLE));

endmodule

// File: tb/pwm_fifo_ctrl_bench.sv
module pwm_fifo_ctrl_bench;

    localparam logic [1:0]  AD_CTRL = 2'd0;
    localparam logic [1:0]  AD_STAT = 2'd1;
    localparam logic [1:0]  AD_SMP  = 2'd2;
    localparam logic [1:0]  AD_PER  = 2'd3;
    localparam logic [31:0] C_EN    = 32'h0000_0001;
    localparam logic [31:0] C_SWR   = 32'h0000_0008;
    localparam logic [31:0] C_BUS   = 32'h0001_0000;
    localparam logic [31:0] C_HF    = 32'h0002_0000;
    localparam logic [31:0] C_INV   = 32'h0004_0000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr;
    logic [1:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        hf_tick;
    logic        pwm_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    pwm_fifo_ctrl u_pwm_fifo_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .hf_tick   (hf_tick),
        .pwm_out   (pwm_out)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n   = 1'b0;
        reg_wr  = 1'b0;
        hf_tick = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // call in cycle 0 of a period; one check per period
    task automatic run_check(input string tag, input int per, input int psc,
                             input int nper, input int smp[8], input bit inv);
        int len;
        len = (per + 2) * (psc + 1);
        for (int j = 0; j < nper; j++) begin
            logic [63:0] obs;
            logic [63:0] expv;
            obs  = '0;
            expv = '0;
            for (int c = 0; c < len; c++) begin
                obs[c]  = pwm_out;
                expv[c] = ((c / (psc + 1)) < smp[j]) ^ inv;
                @(negedge clk);
            end
            chk($sformatf("%s period %0d", tag, j), obs, expv);
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        do_reset();
        rd(AD_CTRL, v); chk("R1 ctrl", v, 0);
        rd(AD_STAT, v); chk("R1 stat", v, 0);
        rd(AD_PER, v);  chk("R1 period", v, 0);
        chk("R1 out", pwm_out, 0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        do_reset();
        wr(AD_CTRL, 32'h01C7_5A50);
        rd(AD_CTRL, v); chk("R2 ctrl readback", v, 32'h01C7_5A50);
        chk("R11 idle out with inversion", pwm_out, 0);
        wr(AD_PER, 32'hFFFF_BEEF);
        rd(AD_PER, v); chk("R2 period readback", v, 32'h0000_BEEF);
        rd(AD_SMP, v); chk("R2 sample reads zero", v, 0);
    endtask

    task automatic t_fifo_order();
        logic [31:0] v;
        int s[8];
        do_reset();
        wr(AD_PER, 3);
        for (int i = 1; i <= 4; i++) begin
            wr(AD_SMP, i);
            rd(AD_STAT, v); chk("R3 occupancy", v, i);
        end
        wr(AD_SMP, 0);
        rd(AD_STAT, v); chk("R4 drop sets flag", v, 32'h14);
        wr(AD_STAT, 32'h10);
        rd(AD_STAT, v); chk("R4 flag cleared", v, 32'h04);
        wr(AD_CTRL, C_BUS | C_EN);
        rd(AD_STAT, v); chk("R7 first sample taken at enable", v, 3);
        s = '{1, 2, 3, 4, 4, 4, 4, 4};
        run_check("R7 order", 3, 0, 6, s, 1'b0);
        rd(AD_STAT, v); chk("R7 queue drained", v, 0);
    endtask

    task automatic t_shape();
        int s[8];
        do_reset();
        wr(AD_PER, 3);
        wr(AD_SMP, 0);
        wr(AD_SMP, 5);
        wr(AD_SMP, 2);
        wr(AD_CTRL, C_BUS | C_EN | (32'd2 << 4));
        s = '{0, 5, 2, 2, 2, 2, 2, 2};
        run_check("R5/R6 divided widths", 3, 2, 4, s, 1'b0);
        do_reset();
        wr(AD_PER, 0);
        wr(AD_SMP, 1);
        wr(AD_CTRL, C_BUS | C_EN);
        s = '{1, 1, 1, 1, 1, 1, 1, 1};
        run_check("R5 shortest period", 0, 0, 3, s, 1'b0);
    endtask

    task automatic t_slot();
        logic [31:0] v;
        do_reset();
        wr(AD_PER, 2);
        wr(AD_CTRL, C_BUS | C_EN | (32'd9 << 4));
        for (int i = 0; i < 4; i++) wr(AD_SMP, i + 1);
        rd(AD_STAT, v); chk("R8 full", v, 4);
        repeat (35) @(negedge clk);
        rd(AD_STAT, v); chk("R8 still full at last step", v, 4);
        @(negedge clk);
        rd(AD_STAT, v); chk("R8 slot after boundary", v, 3);
    endtask

    task automatic t_inv();
        int s[8];
        do_reset();
        wr(AD_PER, 1);
        wr(AD_SMP, 1);
        wr(AD_CTRL, C_BUS | C_EN | C_INV);
        s = '{1, 1, 1, 1, 1, 1, 1, 1};
        run_check("R9 inverted", 1, 0, 3, s, 1'b1);
    endtask

    task automatic t_clksel();
        logic [11:0] obs;
        int s[8];
        s = '{1, 1, 1, 1, 1, 1, 1, 1};
        do_reset();
        wr(AD_PER, 1);
        wr(AD_SMP, 1);
        wr(AD_CTRL, C_HF | C_EN);
        for (int c = 0; c < 12; c++) begin
            obs[c] = pwm_out;
            @(negedge clk);
        end
        chk("R10 alt source stalled", obs, 12'hFFF);
        hf_tick = 1'b1;
        run_check("R10 alt source running", 1, 0, 3, s, 1'b0);
        hf_tick = 1'b0;
        do_reset();
        wr(AD_PER, 1);
        wr(AD_SMP, 1);
        wr(AD_CTRL, C_EN);
        for (int c = 0; c < 12; c++) begin
            obs[c] = pwm_out;
            @(negedge clk);
        end
        chk("R10 no source holds level", obs, 12'hFFF);
    endtask

    task automatic t_stop();
        logic [31:0] v;
        logic [7:0]  obs;
        int s[8];
        s = '{1, 1, 1, 1, 1, 1, 1, 1};
        do_reset();
        wr(AD_PER, 1);
        for (int i = 0; i < 3; i++) wr(AD_SMP, 1);
        wr(AD_CTRL, C_BUS | C_EN);
        run_check("R11 before stop", 1, 0, 1, s, 1'b0);
        wr(AD_CTRL, 0);
        for (int c = 0; c < 8; c++) begin
            obs[c] = pwm_out;
            @(negedge clk);
        end
        chk("R11 output stopped", obs, 0);
        rd(AD_STAT, v); chk("R11 queue kept", v, 1);
    endtask

    task automatic t_swr();
        logic [31:0] v;
        int s[8];
        do_reset();
        wr(AD_PER, 7);
        for (int i = 0; i < 3; i++) wr(AD_SMP, 3);
        wr(AD_CTRL, C_BUS | C_EN | C_INV);
        repeat (3) @(negedge clk);
        wr(AD_CTRL, C_SWR);
        rd(AD_CTRL, v); chk("R12 busy bit first cycle", v, 32'h8);
        wr(AD_PER, 32'h55);
        repeat (6) @(negedge clk);
        rd(AD_CTRL, v); chk("R12 busy bit last cycle", v, 32'h8);
        @(negedge clk);
        rd(AD_CTRL, v); chk("R12 busy bit cleared", v, 0);
        rd(AD_STAT, v); chk("R12 queue flushed", v, 0);
        rd(AD_PER, v);  chk("R12 write ignored and period cleared", v, 0);
        chk("R12 output low", pwm_out, 0);
        wr(AD_SMP, 1);
        wr(AD_CTRL, C_BUS | C_EN);
        s = '{1, 1, 1, 1, 1, 1, 1, 1};
        run_check("R12 usable after reset", 0, 0, 2, s, 1'b0);
    endtask

    initial begin
        rst_n     = 1'b0;
        reg_wr    = 1'b0;
        reg_addr  = '0;
        reg_wdata = '0;
        hf_tick   = 1'b0;
        t_reset();
        t_regs();
        t_fifo_order();
        t_shape();
        t_slot();
        t_inv();
        t_clksel();
        t_stop();
        t_swr();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule